// File: doc/BRIEF.md
# Codec Register Access Engine over a Serial Audio Link

This block gives a host processor access to the control registers of an external audio codec that sits on a time-multiplexed serial link. The host sees a small bank of 32-bit registers, four bytes apart. To reach the codec, the host writes one command word holding a direction bit, a 7-bit codec register index and 16 data bits. The engine sends that command in the next outgoing link frame. It reports completion through two sticky flags, which the host polls or routes to an interrupt.

On the link, each frame is 256 bits long. A 16-bit tag slot comes first, followed by twelve 20-bit slots, and the frame-sync output is high for the whole tag slot. The command index travels in slot 1 and the write data in slot 2. Tag bits mark which of those slots are valid, and they are set only in the frame that carries a command. For a read, the engine watches the incoming frames for a status reply whose index matches the request. It then places the returned 16 bits into the low half of the command register. A control register lets the host force a cold reset of the link and move it into and out of a low-power sleep state. Audio sample slots are not handled here.

Top module: `codec_cmd_engine`

## Requirements
- R1: While `rst` is high and for exactly RESET_CYCLES cycles after it falls, `codec_rst_n` is low and `link_sync` and `link_sdout` are low. Control bit 1 (offset 0x00) reads 1 in that time and 0 once frames run. The raw flags (offset 0x54) and `irq` are 0 after reset.
- R2: Each frame is 256 cycles long and `link_sync` is high for its first 16 cycles. Link bit 0 (tag bit 15, frame valid) is 1 in every frame. Link bits 1 and 2 (slot-1 and slot-2 valid) are 1 only in the frame that carries a command.
- R3: The command register at offset 0x18 holds the direction in bit 31 (1 = codec read, 0 = codec write), the index in bits 22:16 and the data in bits 15:0. The next frame that starts after the command is accepted sends slot 1 as {direction, index, 12 zeros} on link bits 16..35, MSB first. For a write it also sends slot 2 as {data, 4 zeros} on link bits 36..55; for a read, slot 2 is not marked valid.
- R4: The write-done flag (bit 1 at 0x54) is set in the cycle right after the last bit of the frame that carried the write.
- R5: The read-done flag (bit 0 at 0x54) is set in the cycle right after the last bit of an incoming frame that meets three conditions: `link_sdin` bits 0, 1 and 2 are all 1, the index in link bits 17..23 equals the requested one, and 16 data bits are present on link bits 36..51. At that point, bits 15:0 of the command register hold the returned data. A reply with a different index sets nothing.
- R6: A bus read of 0x68 clears write-done and a bus read of 0x6C clears read-done; both reads return 0. A write to 0x54 keeps only the flags whose write-data bit is 1, so writing 0 clears both.
- R7: `irq` is 1 exactly when a raw flag is set and the matching bit of the mask register (0x58, bits 1:0) is 1.
- R8: A command written while another is still pending is ignored and leaves the command register unchanged.
- R9: Writing control bit 0 as 1 forces a cold reset that lasts RESET_CYCLES cycles and drops any pending command. Control bit 0 always reads 0.
- R10: Writing control bit 1 as 1 while frames run puts the link to sleep at the end of the current frame. While asleep, `link_sync` stays low, no command is sent and control bit 1 reads 1. Writing bit 1 as 1 again wakes the link after WAKE_CYCLES cycles; bit 1 then reads 0 and a queued command goes out in the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one link bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read-to-clear) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Masked completion interrupt |
| codec_rst_n | output | 1 | Active-low cold reset to the codec |
| link_sync | output | 1 | Frame sync, high during the tag slot |
| link_sdout | output | 1 | Serial data to the codec |
| link_sdin | input | 1 | Serial data from the codec |

## Verification
Write-done is due one cycle after the last bit of the frame that carried the write. Read-done is due one cycle after the last bit of the codec's reply frame, which follows the request frame. The behavioural codec notes the cycle in which it decodes each of those frame ends, and the bench requires the first `irq` edge exactly one cycle later. The cold-reset window is measured by counting, on falling edges, the cycles in which `codec_rst_n` is low, and the count must equal RESET_CYCLES. The sleep transitions are bounded by polling the control register within a frame's length, or within WAKE_CYCLES for waking.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;

    localparam int FRAME_BITS = 256;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int SLOT1_LO   = TAG_BITS;
    localparam int SLOT2_LO   = TAG_BITS + SLOT_BITS;
    localparam int ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_WCLR = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_RCLR = 8'h6C;

    typedef enum logic [1:0] {LNK_COLD, LNK_RUN, LNK_SLEEP, LNK_WAKE} link_state_e;
    typedef enum logic [1:0] {CMD_IDLE, CMD_QUEUED, CMD_SENDING, CMD_AWAIT} cmd_phase_e;

    typedef struct packed {
        logic        rd;
        logic [6:0]  idx;
        logic [15:0] data;
    } codec_cmd_t;

    typedef struct packed {
        logic [6:0]  idx;
        logic [15:0] data;
    } codec_status_t;

    function automatic logic [SLOT_BITS-1:0] addr_slot(input codec_cmd_t c);
        return {c.rd, c.idx, 12'h000};
    endfunction

    function automatic logic [SLOT_BITS-1:0] data_slot(input codec_cmd_t c);
        return {c.data, 4'h0};
    endfunction

    // Serial bit at frame position pos, MSB of each slot first.
    function automatic logic frame_bit(input logic [CNT_W-1:0] pos,
                                       input logic [TAG_BITS-1:0] tag,
                                       input logic [SLOT_BITS-1:0] s1,
                                       input logic [SLOT_BITS-1:0] s2);
        logic [CNT_W-1:0] off1;
        logic [CNT_W-1:0] off2;
        logic             b;
        off1 = pos - CNT_W'(SLOT1_LO);
        off2 = pos - CNT_W'(SLOT2_LO);
        if (pos < CNT_W'(SLOT1_LO))
            b = tag[4'd15 - pos[3:0]];
        else if (pos < CNT_W'(SLOT2_LO))
            b = s1[5'd19 - off1[4:0]];
        else if (pos < CNT_W'(SLOT2_LO + SLOT_BITS))
            b = s2[5'd19 - off2[4:0]];
        else
            b = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/codec_link_seq.sv
module codec_link_seq
    import codec_link_pkg::*;
#(
    parameter int RESET_CYCLES = 12,
    parameter int WAKE_CYCLES  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             force_cold,
    input  logic             sleep_toggle,
    output logic             link_run,
    output logic             link_settling,
    output logic             frame_first,
    output logic             frame_last,
    output logic [CNT_W-1:0] bit_pos,
    output logic             codec_rst_n,
    output logic             link_sync
);
    localparam int TMAX = (RESET_CYCLES > WAKE_CYCLES) ? RESET_CYCLES : WAKE_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);

    link_state_e     state;
    logic [TW-1:0]   timer;
    logic            sleep_req;

    always_ff @(posedge clk) begin
        if (rst || force_cold) begin
            state     <= LNK_COLD;
            timer     <= '0;
            bit_pos   <= '0;
            sleep_req <= 1'b0;
        end else begin
            case (state)
                LNK_COLD: begin
                    if (timer == TW'(RESET_CYCLES - 1)) begin
                        state   <= LNK_RUN;
                        timer   <= '0;
                        bit_pos <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                LNK_RUN: begin
                    bit_pos <= bit_pos + 1'b1;
                    if (sleep_toggle)
                        sleep_req <= 1'b1;
                    if (frame_last && (sleep_req || sleep_toggle)) begin
                        state     <= LNK_SLEEP;
                        sleep_req <= 1'b0;
                        bit_pos   <= '0;
                    end
                end
                LNK_SLEEP: begin
                    if (sleep_toggle) begin
                        state <= LNK_WAKE;
                        timer <= '0;
                    end
                end
                default: begin
                    if (timer == TW'(WAKE_CYCLES - 1)) begin
                        state   <= LNK_RUN;
                        timer   <= '0;
                        bit_pos <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
            endcase
        end
    end

    assign link_run      = (state == LNK_RUN);
    assign link_settling = (state != LNK_RUN);
    assign frame_first   = link_run && (bit_pos == '0);
    assign frame_last    = link_run && (bit_pos == CNT_W'(FRAME_BITS - 1));
    assign codec_rst_n   = (state != LNK_COLD);
    assign link_sync     = link_run && (bit_pos < CNT_W'(TAG_BITS));

endmodule

// File: rtl/codec_frame_tx.sv
module codec_frame_tx
    import codec_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             link_run,
    input  logic             frame_first,
    input  logic [CNT_W-1:0] bit_pos,
    input  logic             load_cmd,
    input  codec_cmd_t       cmd,
    output logic             sdout
);
    logic                 v_addr;
    logic                 v_data;
    logic [SLOT_BITS-1:0] s1_q;
    logic [SLOT_BITS-1:0] s2_q;
    logic [TAG_BITS-1:0]  tag;

    // Slot contents are latched at the first bit; bit 0 itself is constant.
    always_ff @(posedge clk) begin
        if (rst) begin
            v_addr <= 1'b0;
            v_data <= 1'b0;
            s1_q   <= '0;
            s2_q   <= '0;
        end else if (frame_first) begin
            v_addr <= load_cmd;
            v_data <= load_cmd && !cmd.rd;
            s1_q   <= load_cmd ? addr_slot(cmd) : '0;
            s2_q   <= (load_cmd && !cmd.rd) ? data_slot(cmd) : '0;
        end
    end

    assign tag   = {1'b1, v_addr, v_data, 13'h0000};
    assign sdout = link_run && ((bit_pos == '0) ? 1'b1 : frame_bit(bit_pos, tag, s1_q, s2_q));

endmodule

// File: rtl/codec_frame_rx.sv
module codec_frame_rx
    import codec_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             link_run,
    input  logic             frame_last,
    input  logic [CNT_W-1:0] bit_pos,
    input  logic             sdin,
    output logic             stat_valid,
    output codec_status_t    stat
);
    localparam int IDX_LO  = SLOT1_LO + 1;
    localparam int DATA_LO = SLOT2_LO;

    logic [2:0]       tag_q;
    logic [6:0]       idx_q;
    logic [15:0]      data_q;
    logic [CNT_W-1:0] off_idx;
    logic [CNT_W-1:0] off_data;

    assign off_idx  = bit_pos - CNT_W'(IDX_LO);
    assign off_data = bit_pos - CNT_W'(DATA_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (link_run) begin
            if (bit_pos < CNT_W'(3))
                tag_q[2'd2 - bit_pos[1:0]] <= sdin;
            else if (bit_pos >= CNT_W'(IDX_LO) && bit_pos < CNT_W'(IDX_LO + 7))
                idx_q[3'd6 - off_idx[2:0]] <= sdin;
            else if (bit_pos >= CNT_W'(DATA_LO) && bit_pos < CNT_W'(DATA_LO + 16))
                data_q[4'd15 - off_data[3:0]] <= sdin;
        end
    end

    assign stat_valid = frame_last && (&tag_q);
    assign stat.idx   = idx_q;
    assign stat.data  = data_q;

endmodule

// File: rtl/codec_host_regs.sv
module codec_host_regs
    import codec_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              codec_rst_n,
    input  logic              link_settling,
    input  logic              frame_first,
    input  logic              frame_last,
    input  logic              stat_valid,
    input  codec_status_t     stat,
    output logic              force_cold,
    output logic              sleep_toggle,
    output logic              cmd_queued,
    output logic              cmd_busy,
    output codec_cmd_t        cmd_q,
    output logic [1:0]        raw_flags,
    output logic              irq
);
    cmd_phase_e  phase;
    logic [1:0]  mask_q;
    logic [1:0]  raw_nxt;
    logic        accept;
    logic        wr_done_set;
    logic        rd_done_set;
    logic        unused_wdata;

    assign unused_wdata = ^bus_wdata[30:23];

    assign force_cold   = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0];
    assign sleep_toggle = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[1] && !bus_wdata[0];
    assign accept       = bus_wr && (bus_addr == OFS_CMD) && (phase == CMD_IDLE);
    assign wr_done_set  = (phase == CMD_SENDING) && frame_last && !cmd_q.rd;
    assign rd_done_set  = (phase == CMD_AWAIT) && stat_valid && (stat.idx == cmd_q.idx);
    assign cmd_queued   = (phase == CMD_QUEUED);
    assign cmd_busy     = (phase != CMD_IDLE);

    always_comb begin
        raw_nxt = raw_flags;
        if (bus_wr && bus_addr == OFS_RAW)
            raw_nxt = raw_nxt & bus_wdata[1:0];
        if (bus_rd && bus_addr == OFS_WCLR)
            raw_nxt[1] = 1'b0;
        if (bus_rd && bus_addr == OFS_RCLR)
            raw_nxt[0] = 1'b0;
        if (wr_done_set)
            raw_nxt[1] = 1'b1;
        if (rd_done_set)
            raw_nxt[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= CMD_IDLE;
            cmd_q     <= '0;
            raw_flags <= '0;
            mask_q    <= '0;
        end else begin
            raw_flags <= raw_nxt;
            if (bus_wr && bus_addr == OFS_MASK)
                mask_q <= bus_wdata[1:0];
            if (!codec_rst_n) begin
                phase <= CMD_IDLE;
            end else begin
                case (phase)
                    CMD_IDLE: begin
                        if (accept) begin
                            cmd_q.rd   <= bus_wdata[31];
                            cmd_q.idx  <= bus_wdata[22:16];
                            cmd_q.data <= bus_wdata[15:0];
                            phase      <= CMD_QUEUED;
                        end
                    end
                    CMD_QUEUED: begin
                        if (frame_first)
                            phase <= CMD_SENDING;
                    end
                    CMD_SENDING: begin
                        if (frame_last)
                            phase <= cmd_q.rd ? CMD_AWAIT : CMD_IDLE;
                    end
                    default: begin
                        if (rd_done_set) begin
                            cmd_q.data <= stat.data;
                            phase      <= CMD_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = {30'h0, link_settling, 1'b0};
            OFS_CMD:  bus_rdata = {cmd_q.rd, 8'h00, cmd_q.idx, cmd_q.data};
            OFS_RAW:  bus_rdata = {30'h0, raw_flags};
            OFS_MASK: bus_rdata = {30'h0, mask_q};
            default:  bus_rdata = 32'h0;
        endcase
    end

    assign irq = |(raw_flags & mask_q);

endmodule

// File: rtl/codec_cmd_engine.sv
module codec_cmd_engine
    import codec_link_pkg::*;
#(
    parameter int RESET_CYCLES = 12,
    parameter int WAKE_CYCLES  = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        codec_rst_n,
    output logic        link_sync,
    output logic        link_sdout,
    input  logic        link_sdin
);
    logic             force_cold;
    logic             sleep_toggle;
    logic             link_run;
    logic             link_settling;
    logic             frame_first;
    logic             frame_last;
    logic [CNT_W-1:0] bit_pos;
    logic             stat_valid;
    codec_status_t    stat;
    logic             cmd_queued;
    logic             cmd_busy;
    codec_cmd_t       cmd_q;
    logic [1:0]       raw_flags;

    codec_link_seq #(
        .RESET_CYCLES (RESET_CYCLES),
        .WAKE_CYCLES  (WAKE_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .force_cold    (force_cold),
        .sleep_toggle  (sleep_toggle),
        .link_run      (link_run),
        .link_settling (link_settling),
        .frame_first   (frame_first),
        .frame_last    (frame_last),
        .bit_pos       (bit_pos),
        .codec_rst_n   (codec_rst_n),
        .link_sync     (link_sync)
    );

    codec_frame_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .link_run    (link_run),
        .frame_first (frame_first),
        .bit_pos     (bit_pos),
        .load_cmd    (cmd_queued),
        .cmd         (cmd_q),
        .sdout       (link_sdout)
    );

    codec_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .link_run   (link_run),
        .frame_last (frame_last),
        .bit_pos    (bit_pos),
        .sdin       (link_sdin),
        .stat_valid (stat_valid),
        .stat       (stat)
    );

    codec_host_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .codec_rst_n   (codec_rst_n),
        .link_settling (link_settling),
        .frame_first   (frame_first),
        .frame_last    (frame_last),
        .stat_valid    (stat_valid),
        .stat          (stat),
        .force_cold    (force_cold),
        .sleep_toggle  (sleep_toggle),
        .cmd_queued    (cmd_queued),
        .cmd_busy      (cmd_busy),
        .cmd_q         (cmd_q),
        .raw_flags     (raw_flags),
        .irq           (irq)
    );

endmodule

// File: rtl/codec_cmd_engine_chk.sv
module codec_cmd_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       codec_rst_n,
    input logic       link_sync,
    input logic       link_sdout,
    input logic       frame_last,
    input logic       stat_valid,
    input logic [1:0] raw_flags,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_addr,
    input logic       cmd_busy,
    input logic       cmd_rd,
    input logic [6:0] cmd_idx
);
    AST_COLD_LINK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !codec_rst_n |-> (!link_sync && !link_sdout)); // R1

    AST_WDONE_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_flags[1]) |-> $past(frame_last)); // R4

    AST_RDONE_ON_STATUS: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_flags[0]) |-> $past(stat_valid)); // R5

    AST_WCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h68 && !frame_last) |=> !raw_flags[1]); // R6

    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && bus_wr && bus_addr == 8'h18) |=>
            (cmd_rd == $past(cmd_rd) && cmd_idx == $past(cmd_idx))); // R8

endmodule

bind codec_cmd_engine codec_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .codec_rst_n (codec_rst_n),
    .link_sync   (link_sync),
    .link_sdout  (link_sdout),
    .frame_last  (frame_last),
    .stat_valid  (stat_valid),
    .raw_flags   (raw_flags),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .cmd_busy    (cmd_busy),
    .cmd_rd      (cmd_q.rd),
    .cmd_idx     (cmd_q.idx)
);

// File: tb/tb_codec_cmd_engine.sv
module tb_codec_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int RC = 12;
    localparam int WC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        codec_rst_n;
    logic        link_sync;
    logic        link_sdout;
    logic        link_sdin = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    codec_cmd_engine #(.RESET_CYCLES(RC), .WAKE_CYCLES(WC)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .codec_rst_n(codec_rst_n),
        .link_sync(link_sync), .link_sdout(link_sdout), .link_sdin(link_sdin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural codec: 64 registers, answers a read in the following frame.
    logic [15:0]  creg [64];
    logic [255:0] fr;
    int  k = 1000;
    bit  prev_sync = 1'b0;
    bit  reply_pend = 1'b0, cur_reply = 1'b0, corrupt = 1'b0;
    logic [6:0]  rep_idx, cur_idx;
    logic [15:0] rep_dat, cur_dat;
    int  frames = 0, cmd_frames = 0, fmt_err = 0, wr_end = -1, rd_end = -1;

    initial for (int i = 0; i < 64; i++) creg[i] = 16'h0;

    always @(negedge clk) begin
        logic [6:0]  fidx;
        logic [15:0] fdat;
        if (!codec_rst_n) begin
            k = 1000; prev_sync = 1'b0; link_sdin = 1'b0;
            reply_pend = 1'b0; cur_reply = 1'b0;
        end else begin
            if (link_sync && !prev_sync) k = 0; else k = k + 1;
            prev_sync = link_sync;
            if (k == 0 && reply_pend) begin
                cur_reply = 1'b1; cur_idx = rep_idx; cur_dat = rep_dat; reply_pend = 1'b0;
            end
            if (k < 256) begin
                fr[k] = link_sdout;
                if ((k < 16) != link_sync) fmt_err++;
                if (k == 0) link_sdin = 1'b1;
                else if (k < 3) link_sdin = cur_reply;
                else if (k >= 17 && k < 24) link_sdin = cur_reply && cur_idx[6 - (k - 17)];
                else if (k >= 36 && k < 52) link_sdin = cur_reply && cur_dat[15 - (k - 36)];
                else link_sdin = 1'b0;
            end else begin
                link_sdin = 1'b0;
            end
            if (k == 255) begin
                frames++;
                if (!fr[0]) fmt_err++;
                for (int b = 0; b < 7; b++) fidx[6 - b] = fr[17 + b];
                for (int b = 0; b < 16; b++) fdat[15 - b] = fr[36 + b];
                if (fr[1]) begin
                    cmd_frames++;
                    if (fr[16] && !fr[2]) begin
                        reply_pend = 1'b1;
                        rep_idx = fidx ^ (corrupt ? 7'h01 : 7'h00);
                        rep_dat = creg[fidx[5:0]];
                    end else if (!fr[16] && fr[2]) begin
                        creg[fidx[5:0]] = fdat;
                        wr_end = cyc;
                    end else fmt_err++;
                end else if (fr[2]) fmt_err++;
                if (cur_reply) begin
                    rd_end = cyc; cur_reply = 1'b0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(output int t);
        t = -1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (irq) begin t = cyc; break; end
        end
    endtask

    task automatic count_cold(output int n);
        n = 0;
        for (int m = 0; m < 1000; m++) begin
            @(negedge clk);
            if (codec_rst_n) break;
            n++;
        end
    endtask

    initial begin
        logic [31:0] rd;
        logic [15:0] d;
        int t, n, cf;
        bit ok;

        repeat (4) @(negedge clk);
        chk(irq == 1'b0 && codec_rst_n == 1'b0, "R1 reset outputs", {30'h0, irq, codec_rst_n}, 32'h0);
        rst = 1'b0;
        n = 1;
        count_cold(t);
        n = n + t;
        chk(n == RC, "R1 cold cycles after reset", n, RC);
        bus_read(8'h00, rd);
        chk(rd == 32'h0, "R1 ctrl after link up", rd, 32'h0);
        bus_read(8'h54, rd);
        chk(rd == 32'h0, "R1 raw flags after reset", rd, 32'h0);
        bus_write(8'h54, 32'h0);
        bus_write(8'h58, 32'h3);
        bus_read(8'h58, rd);
        chk(rd == 32'h3, "R7 mask readback", rd, 32'h3);

        // Write sweep over all 64 codec registers.
        for (int i = 0; i < 64; i++) begin
            d = (16'(i) * 16'h0913) ^ 16'h5A3C;
            cf = cmd_frames;
            bus_write(8'h18, {1'b0, 8'h00, 7'(i), d});
            wait_irq(t);
            chk(t == wr_end + 1, "R4 write-done cycle", t, wr_end + 1);
            chk(cmd_frames == cf + 1, "R2 one tagged frame per command", cmd_frames, cf + 1);
            bus_read(8'h54, rd);
            chk(rd == 32'h2, "R4 write-done flag", rd, 32'h2);
            bus_read(8'h68, rd);
            chk(rd == 32'h0, "R6 clear read returns zero", rd, 32'h0);
            bus_read(8'h54, rd);
            chk(rd == 32'h0, "R6 write-done cleared", rd, 32'h0);
        end
        for (int i = 0; i < 64; i++) begin
            d = (16'(i) * 16'h0913) ^ 16'h5A3C;
            chk(creg[i] == d, "R3 codec register content", creg[i], d);
        end

        // Read sweep.
        for (int i = 0; i < 64; i++) begin
            d = (16'(i) * 16'h0913) ^ 16'h5A3C;
            bus_write(8'h18, {1'b1, 8'h00, 7'(i), 16'h0});
            wait_irq(t);
            chk(t == rd_end + 1, "R5 read-done cycle", t, rd_end + 1);
            bus_read(8'h18, rd);
            chk(rd == {1'b1, 8'h00, 7'(i), d}, "R5 read data in command register", rd, {1'b1, 8'h00, 7'(i), d});
            bus_read(8'h6C, rd);
            bus_read(8'h54, rd);
            chk(rd == 32'h0, "R6 read-done cleared", rd, 32'h0);
        end
        chk(fmt_err == 0, "R2 frame format", fmt_err, 0);
        chk(frames > 300, "R2 frames running", frames, 300);

        // Command written while pending is ignored.
        bus_write(8'h18, {1'b0, 8'h00, 7'd5, 16'hBEEF});
        bus_write(8'h18, {1'b0, 8'h00, 7'd6, 16'h1234});
        bus_read(8'h18, rd);
        chk(rd == {1'b0, 8'h00, 7'd5, 16'hBEEF}, "R8 command register kept", rd, {1'b0, 8'h00, 7'd5, 16'hBEEF});
        wait_irq(t);
        repeat (600) @(negedge clk);
        chk(creg[5] == 16'hBEEF && creg[6] == ((16'd6 * 16'h0913) ^ 16'h5A3C), "R8 second command dropped",
            {creg[5], creg[6]}, {16'hBEEF, (16'd6 * 16'h0913) ^ 16'h5A3C});
        bus_read(8'h68, rd);

        // Mask behaviour.
        bus_write(8'h58, 32'h0);
        bus_write(8'h18, {1'b0, 8'h00, 7'd7, 16'h00A7});
        repeat (600) @(negedge clk);
        chk(irq == 1'b0, "R7 masked flag gives no irq", irq, 0);
        bus_write(8'h58, 32'h1);
        #1 chk(irq == 1'b0, "R7 other mask bit", irq, 0);
        bus_write(8'h58, 32'h2);
        #1 chk(irq == 1'b1, "R7 matching mask bit", irq, 1);
        bus_write(8'h54, 32'h1);
        bus_read(8'h54, rd);
        chk(rd == 32'h0, "R6 raw write clears zero bits", rd, 32'h0);
        bus_write(8'h58, 32'h3);

        // Reply with the wrong index sets nothing; force reset drops it.
        corrupt = 1'b1;
        bus_write(8'h18, {1'b1, 8'h00, 7'd9, 16'h0});
        repeat (1100) @(negedge clk);
        bus_read(8'h54, rd);
        chk(rd == 32'h0, "R5 mismatched index ignored", rd, 32'h0);
        corrupt = 1'b0;
        bus_write(8'h00, 32'h1);
        count_cold(t);
        chk(t == RC, "R9 forced cold reset length", t, RC);
        bus_write(8'h00, 32'h1);
        bus_read(8'h00, rd);
        chk(rd == 32'h2, "R9 ctrl during forced reset", rd, 32'h2);
        count_cold(t);
        bus_write(8'h18, {1'b1, 8'h00, 7'd9, 16'h0});
        wait_irq(t);
        bus_read(8'h18, rd);
        chk(rd == {1'b1, 8'h00, 7'd9, (16'd9 * 16'h0913) ^ 16'h5A3C}, "R9 pending dropped, new read works",
            rd, {1'b1, 8'h00, 7'd9, (16'd9 * 16'h0913) ^ 16'h5A3C});
        bus_read(8'h6C, rd);

        // Sleep and wake.
        bus_write(8'h00, 32'h2);
        ok = 1'b0;
        for (int p = 0; p < 300; p++) begin
            bus_read(8'h00, rd);
            if (rd == 32'h2) begin ok = 1'b1; break; end
        end
        chk(ok, "R10 sleep entered within a frame", rd, 32'h2);
        cf = cmd_frames;
        bus_write(8'h18, {1'b0, 8'h00, 7'd20, 16'h7E57});
        ok = 1'b1;
        for (int p = 0; p < 600; p++) begin
            @(negedge clk);
            if (link_sync) ok = 1'b0;
        end
        chk(ok && cmd_frames == cf, "R10 link quiet while asleep", cmd_frames, cf);
        bus_write(8'h00, 32'h2);
        ok = 1'b0;
        for (int p = 0; p < WC + 4; p++) begin
            bus_read(8'h00, rd);
            if (rd == 32'h0) begin ok = 1'b1; break; end
        end
        chk(ok, "R10 wake completes", rd, 32'h0);
        wait_irq(t);
        chk(t == wr_end + 1 && creg[20] == 16'h7E57, "R10 queued command after wake", creg[20], 16'h7E57);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule